// File: doc/BRIEF.md
# Operator-Combination Equation Checker

The block decides, for a stream of equations, whether the operands of each one can be joined by a choice of binary operators so that the expression gives the stated target. Each equation consists of a target, an operand count and up to `N` operands. Its targets are added up over all equations that can be satisfied. For each accepted equation, a digit counter walks through every operator choice for the gaps between operands and issues one candidate per clock. Each candidate enters an unrolled pipeline that has one stage per gap. The whole equation travels with the candidate, and every stage folds in one more operand, strictly left to right with no precedence.

In the base mode a gap can hold addition or multiplication. In the extended mode, chosen per equation, a gap can also hold decimal concatenation. At the tail of the pipeline, a candidate that reaches the target exactly credits the equation's target to a running sum. A tag and a matched flag make sure that each equation is credited at most once. Equations are grouped into batches. Marking an equation as the last of a batch raises `done` once its final candidate has left the pipeline.

Top module: `opcombo_eval`

## Requirements
- R1: After reset, `sum_out` is 0, `done` is 0 and `in_ready` is 1.
- R2: An equation is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays low for exactly R^(count-1) cycles, where R is 2 in base mode and 3 in extended mode (`in_ext`=1). This gives one candidate per cycle.
- R3: In base mode each gap is addition or multiplication, and operators are applied strictly left to right with no precedence. If any choice equals the target, the target is added to `sum_out`.
- R4: In extended mode a gap may also concatenate: the running value is multiplied by 10 to the number of decimal digits of the next operand, and then that operand is added.
- R5: An equation adds its target to `sum_out` at most once, even when several operator choices match.
- R6: Operands are at least 1. A choice whose running value ever exceeds the target never matches, even where the value would wrap modulo 2^W to the target.
- R7: Only the first `in_count` operands (1 to N) take part in the evaluation. With a count of 1, the equation matches exactly when operand 0 equals the target.
- R8: When `in_last`=1, `in_ready` stays low for R^(count-1)+N-1 cycles after the accept. `done` rises in the same cycle that `in_ready` returns high, and `sum_out` then holds the batch total. The next accept clears `done`.
- R9: While `done` is 1 and no equation is accepted, `done` stays 1 and `sum_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Equation offered |
| in_ready | output | 1 | Equation can be taken |
| in_target | input | W | Target value |
| in_count | input | CW | Number of operands in use (1..N) |
| in_operands | input | N*W | Operand k at bits [k*W +: W] |
| in_ext | input | 1 | 1 selects the three-operator mode |
| in_last | input | 1 | Marks the last equation of a batch |
| sum_out | output | SUM_W | Sum of credited targets |
| done | output | 1 | Batch fully drained |

## Verification
The bench builds the block with W=32, N=4 and SUM_W=48, so each equation has at most 27 operator choices. At that size an arithmetic model in the bench can try every choice of every equation in a sweep of a few hundred equations that mixes both modes and all counts. W=32 also brings the wrap corner within reach: 65537*65536 wraps to exactly the target 65536. Directed equations cover double matches, ignored trailing operands, precedence, and two-digit concatenation.

// File: rtl/opcombo_pkg.sv
package opcombo_pkg;
  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 2'd0,
    OP_MUL = 2'd1,
    OP_CAT = 2'd2
  } op_e;

  // highest digit value of the operator counter for the selected mode
  function automatic logic [OP_W-1:0] digit_max(input logic ext);
    return ext ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/opcombo_gen.sv
module opcombo_gen
  import opcombo_pkg::*;
#(
  parameter int W     = 64,
  parameter int N     = 6,
  parameter int CW    = 3,
  parameter int TAG_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [W-1:0]           in_target,
  input  logic [CW-1:0]          in_count,
  input  logic [N*W-1:0]         in_operands,
  input  logic                   in_ext,
  input  logic                   in_last,
  input  logic                   drain_done,
  output logic                   c_valid,
  output logic [W-1:0]           c_target,
  output logic [N*W-1:0]         c_opnds,
  output logic [(N-1)*OP_W-1:0]  c_ops,
  output logic [CW-1:0]          c_cnt,
  output logic [TAG_W-1:0]       c_tag,
  output logic                   c_fin,
  output logic [W-1:0]           c_acc,
  output logic                   c_over
);
  localparam int G = N - 1;

  logic                  busy;
  logic                  hold;
  logic [W-1:0]          eq_target;
  logic [N*W-1:0]        eq_opnds;
  logic [CW-1:0]         eq_cnt;
  logic                  eq_ext;
  logic                  eq_last;
  logic [TAG_W-1:0]      tag_q;
  logic [G-1:0][OP_W-1:0] dig;
  logic [G-1:0][OP_W-1:0] dig_nxt;
  logic                  last_cand;
  logic                  accept;

  assign in_ready = !busy && !hold;
  assign accept   = in_valid && in_ready;

  // ripple increment across the gaps that are in use
  always_comb begin
    logic             carry;
    logic [OP_W-1:0]  dmax;
    carry = 1'b1;
    dmax  = digit_max(eq_ext);
    for (int i = 0; i < G; i++) begin
      dig_nxt[i] = dig[i];
      if (((i + 1) < int'(eq_cnt)) && carry) begin
        if (dig[i] == dmax) begin
          dig_nxt[i] = '0;
        end else begin
          dig_nxt[i] = dig[i] + 1'b1;
          carry      = 1'b0;
        end
      end
    end
    last_cand = carry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      hold      <= 1'b0;
      tag_q     <= '0;
      dig       <= '0;
      eq_target <= '0;
      eq_opnds  <= '0;
      eq_cnt    <= '0;
      eq_ext    <= 1'b0;
      eq_last   <= 1'b0;
    end else begin
      if (accept) begin
        eq_target <= in_target;
        eq_opnds  <= in_operands;
        eq_cnt    <= in_count;
        eq_ext    <= in_ext;
        eq_last   <= in_last;
        dig       <= '0;
        busy      <= 1'b1;
        tag_q     <= tag_q + 1'b1;
      end else if (busy) begin
        dig <= dig_nxt;
        if (last_cand) begin
          busy <= 1'b0;
          if (eq_last) hold <= 1'b1;
        end
      end
      if (drain_done) hold <= 1'b0;
    end
  end

  assign c_valid  = busy;
  assign c_target = eq_target;
  assign c_opnds  = eq_opnds;
  assign c_ops    = dig;
  assign c_cnt    = eq_cnt;
  assign c_tag    = tag_q;
  assign c_fin    = eq_last && last_cand;
  assign c_acc    = eq_opnds[W-1:0];
  assign c_over   = eq_opnds[W-1:0] > eq_target;
endmodule

// File: rtl/opcombo_stage.sv
module opcombo_stage
  import opcombo_pkg::*;
#(
  parameter int W     = 64,
  parameter int N     = 6,
  parameter int CW    = 3,
  parameter int TAG_W = 2,
  parameter int IDX   = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s_valid,
  input  logic [W-1:0]          s_target,
  input  logic [N*W-1:0]        s_opnds,
  input  logic [(N-1)*OP_W-1:0] s_ops,
  input  logic [CW-1:0]         s_cnt,
  input  logic [TAG_W-1:0]      s_tag,
  input  logic                  s_fin,
  input  logic [W-1:0]          s_acc,
  input  logic                  s_over,
  output logic                  q_valid,
  output logic [W-1:0]          q_target,
  output logic [N*W-1:0]        q_opnds,
  output logic [(N-1)*OP_W-1:0] q_ops,
  output logic [CW-1:0]         q_cnt,
  output logic [TAG_W-1:0]      q_tag,
  output logic                  q_fin,
  output logic [W-1:0]          q_acc,
  output logic                  q_over
);
  // wide enough for acc * 10^digits without wrapping
  localparam int WW   = 2 * W + 4;
  localparam int MAXD = (W * 3) / 10 + 2;

  function automatic logic [WW-1:0] pow10_above(input logic [W-1:0] v);
    logic [WW-1:0] p;
    p = WW'(10);
    for (int k = 0; k < MAXD; k++) begin
      if (p <= WW'(v)) p = p * WW'(10);
    end
    return p;
  endfunction

  logic [W-1:0]  opnd;
  op_e           op;
  logic          active;
  logic [WW-1:0] p10;
  logic [WW-1:0] res;
  logic          nover;

  always_comb begin
    opnd   = s_opnds[(IDX+1)*W +: W];
    op     = op_e'(s_ops[IDX*OP_W +: OP_W]);
    active = (IDX + 1) < int'(s_cnt);
    p10    = pow10_above(opnd);
    case (op)
      OP_MUL:  res = WW'(s_acc) * WW'(opnd);
      OP_CAT:  res = WW'(s_acc) * p10 + WW'(opnd);
      default: res = WW'(s_acc) + WW'(opnd);
    endcase
    nover = s_over || (res > WW'(s_target));
  end

  always_ff @(posedge clk) begin
    if (rst) q_valid <= 1'b0;
    else     q_valid <= s_valid;
  end

  always_ff @(posedge clk) begin
    q_target <= s_target;
    q_opnds  <= s_opnds;
    q_ops    <= s_ops;
    q_cnt    <= s_cnt;
    q_tag    <= s_tag;
    q_fin    <= s_fin;
    q_acc    <= active ? res[W-1:0] : s_acc;
    q_over   <= active ? nover : s_over;
  end
endmodule

// File: rtl/opcombo_acc.sv
module opcombo_acc #(
  parameter int W     = 64,
  parameter int TAG_W = 2,
  parameter int SUM_W = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_valid,
  input  logic [W-1:0]     a_target,
  input  logic [W-1:0]     a_acc,
  input  logic             a_over,
  input  logic [TAG_W-1:0] a_tag,
  input  logic             a_fin,
  input  logic             clr,
  output logic [SUM_W-1:0] sum_q,
  output logic             done_q,
  output logic             fin_exit
);
  logic [TAG_W-1:0] cur_tag;
  logic             hit;
  logic             ok;
  logic             same;
  logic             credit;

  assign ok       = a_valid && !a_over && (a_acc == a_target);
  assign same     = (a_tag == cur_tag);
  assign credit   = ok && !(same && hit);
  assign fin_exit = a_valid && a_fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      done_q  <= 1'b0;
      cur_tag <= '0;
      hit     <= 1'b0;
    end else begin
      if (a_valid) begin
        cur_tag <= a_tag;
        hit     <= (same && hit) || ok;
      end
      if (credit) sum_q <= sum_q + SUM_W'(a_target);
      if (fin_exit)  done_q <= 1'b1;
      else if (clr)  done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/opcombo_eval.sv
module opcombo_eval
  import opcombo_pkg::*;
#(
  parameter int W     = 64,
  parameter int N     = 6,
  parameter int CW    = 3,
  parameter int TAG_W = 2,
  parameter int SUM_W = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_target,
  input  logic [CW-1:0]    in_count,
  input  logic [N*W-1:0]   in_operands,
  input  logic             in_ext,
  input  logic             in_last,
  output logic [SUM_W-1:0] sum_out,
  output logic             done
);
  localparam int G  = N - 1;
  localparam int OW = G * OP_W;

  logic             v_c  [0:G];
  logic [W-1:0]     t_c  [0:G];
  logic [N*W-1:0]   o_c  [0:G];
  logic [OW-1:0]    p_c  [0:G];
  logic [CW-1:0]    n_c  [0:G];
  logic [TAG_W-1:0] g_c  [0:G];
  logic             f_c  [0:G];
  logic [W-1:0]     a_c  [0:G];
  logic             x_c  [0:G];
  logic             drain_done;
  logic             accept;

  assign accept = in_valid && in_ready;

  opcombo_gen #(.W(W), .N(N), .CW(CW), .TAG_W(TAG_W)) u_gen (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_target(in_target), .in_count(in_count), .in_operands(in_operands),
    .in_ext(in_ext), .in_last(in_last), .drain_done(drain_done),
    .c_valid(v_c[0]), .c_target(t_c[0]), .c_opnds(o_c[0]), .c_ops(p_c[0]),
    .c_cnt(n_c[0]), .c_tag(g_c[0]), .c_fin(f_c[0]), .c_acc(a_c[0]), .c_over(x_c[0])
  );

  for (genvar s = 0; s < G; s++) begin : g_stage
    opcombo_stage #(.W(W), .N(N), .CW(CW), .TAG_W(TAG_W), .IDX(s)) u_stage (
      .clk(clk), .rst(rst),
      .s_valid(v_c[s]), .s_target(t_c[s]), .s_opnds(o_c[s]), .s_ops(p_c[s]),
      .s_cnt(n_c[s]), .s_tag(g_c[s]), .s_fin(f_c[s]), .s_acc(a_c[s]), .s_over(x_c[s]),
      .q_valid(v_c[s+1]), .q_target(t_c[s+1]), .q_opnds(o_c[s+1]), .q_ops(p_c[s+1]),
      .q_cnt(n_c[s+1]), .q_tag(g_c[s+1]), .q_fin(f_c[s+1]), .q_acc(a_c[s+1]), .q_over(x_c[s+1])
    );
  end

  opcombo_acc #(.W(W), .TAG_W(TAG_W), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst),
    .a_valid(v_c[G]), .a_target(t_c[G]), .a_acc(a_c[G]), .a_over(x_c[G]),
    .a_tag(g_c[G]), .a_fin(f_c[G]), .clr(accept),
    .sum_q(sum_out), .done_q(done), .fin_exit(drain_done)
  );
endmodule

// File: rtl/opcombo_eval_chk.sv
module opcombo_eval_chk #(
  parameter int SUM_W = 80
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [SUM_W-1:0] sum_out,
  input logic             done
);
  // R2: an accepted equation blocks the port on the next cycle
  p_accept_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R3: credited targets only ever add to the sum
  p_sum_grows_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sum_out >= $past(sum_out)));

  // R8: a finished batch leaves the port open
  p_done_ready_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> in_ready);

  // R8: accepting a new equation clears done
  p_accept_clears_done_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !done);

  // R8: done rises only after the port was held closed
  p_done_after_drain_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(!in_ready));

  // R9: idle after done keeps done and the sum
  p_done_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !in_valid) |=> (done && $stable(sum_out)));
endmodule

bind opcombo_eval opcombo_eval_chk #(.SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .sum_out(sum_out), .done(done)
);

// File: tb/test_opcombo_eval.sv
module test_opcombo_eval;
  localparam int W     = 32;
  localparam int N     = 4;
  localparam int CW    = 3;
  localparam int TAG_W = 2;
  localparam int SUM_W = 48;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [W-1:0]     in_target = '0;
  logic [CW-1:0]    in_count = '0;
  logic [N*W-1:0]   in_operands = '0;
  logic             in_ext = 1'b0;
  logic             in_last = 1'b0;
  logic [SUM_W-1:0] sum_out;
  logic             done;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [SUM_W-1:0] exp_sum = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  opcombo_eval #(.W(W), .N(N), .CW(CW), .TAG_W(TAG_W), .SUM_W(SUM_W)) i_opcombo_eval (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_target(in_target), .in_count(in_count), .in_operands(in_operands),
    .in_ext(in_ext), .in_last(in_last), .sum_out(sum_out), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input logic cond, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  function automatic logic [127:0] apply_op(input int d, input logic [127:0] v, input logic [31:0] o);
    logic [127:0] p;
    p = 128'd10;
    while (p <= 128'(o)) p = p * 10;
    case (d)
      0:       return v + 128'(o);
      1:       return v * 128'(o);
      default: return v * p + 128'(o);
    endcase
  endfunction

  // spec model: try every operator choice, left to right, never exceed target
  function automatic logic model_ok(input logic [31:0] t, input int c, input logic [31:0] o [4], input logic ext);
    int r;
    int tot;
    r = ext ? 3 : 2;
    tot = 1;
    for (int i = 0; i < c - 1; i++) tot = tot * r;
    for (int idx = 0; idx < tot; idx++) begin
      logic [127:0] v;
      logic ov;
      int rem;
      v = 128'(o[0]);
      ov = v > 128'(t);
      rem = idx;
      for (int i = 1; i < c; i++) begin
        v = apply_op(rem % r, v, o[i]);
        rem = rem / r;
        if (v > 128'(t)) ov = 1'b1;
      end
      if (!ov && v == 128'(t)) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic send_eq(input logic [31:0] t, input int c, input logic [31:0] o [4],
                         input logic ext, input logic last, input string req);
    int n;
    int expc;
    logic was_done;
    while (!in_ready) @(negedge clk);
    was_done = done;
    in_valid    = 1'b1;
    in_target   = t;
    in_count    = CW'(c);
    in_operands = {o[3], o[2], o[1], o[0]};
    in_ext      = ext;
    in_last     = last;
    @(negedge clk);
    in_valid = 1'b0;
    if (was_done) check(done == 1'b0, "R8 done cleared on accept", 64'(done), 0);
    n = 0;
    while (!in_ready) begin
      n++;
      @(negedge clk);
    end
    expc = 1;
    for (int i = 0; i < c - 1; i++) expc = expc * (ext ? 3 : 2);
    if (last) expc = expc + N - 1;
    check(n == expc, last ? "R8 busy span" : "R2 busy span", 64'(n), 64'(expc));
    if (model_ok(t, c, o, ext)) exp_sum = exp_sum + SUM_W'(t);
    if (last) begin
      check(done == 1'b1, "R8 done at drain", 64'(done), 1);
      check(sum_out == exp_sum, req, 64'(sum_out), 64'(exp_sum));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sum_out == 0, "R1 sum", 64'(sum_out), 0);
    check(done == 0, "R1 done", 64'(done), 0);
    check(in_ready == 1, "R1 ready", 64'(in_ready), 1);

    // R5: 2+2 and 2*2 both reach 4, credited once
    send_eq(32'd4, 2, '{2, 2, 0, 0}, 1'b0, 1'b1, "R5 single credit");
    check(sum_out == 4, "R5 sum value", 64'(sum_out), 4);
    // R7: count 1, junk operands ignored
    send_eq(32'd7, 1, '{7, 99, 99, 99}, 1'b0, 1'b1, "R7 count one");
    // R7: trailing operands beyond count ignored (5+3=8)
    send_eq(32'd8, 2, '{5, 3, 4, 1}, 1'b0, 1'b1, "R7 trailing ignored");
    check(sum_out == 19, "R7 sum value", 64'(sum_out), 19);
    // R6: 65537*65536 wraps to 65536 in 32 bits, must not match
    send_eq(32'd65536, 2, '{65537, 65536, 0, 0}, 1'b0, 1'b1, "R6 wrap rejected");
    check(sum_out == 19, "R6 sum unchanged", 64'(sum_out), 19);
    send_eq(32'd65536, 2, '{1, 65536, 0, 0}, 1'b0, 1'b1, "R6 exact product");
    // R3: left to right, 2+3*4 = 20, while 14 needs precedence
    send_eq(32'd14, 3, '{2, 3, 4, 0}, 1'b0, 1'b1, "R3 no precedence");
    send_eq(32'd20, 3, '{2, 3, 4, 0}, 1'b0, 1'b1, "R3 left to right");
    check(sum_out == 65575, "R3 sum value", 64'(sum_out), 65575);
    // R4: concatenation in extended mode only
    send_eq(32'd156, 2, '{15, 6, 0, 0}, 1'b0, 1'b1, "R4 base has no concat");
    send_eq(32'd156, 2, '{15, 6, 0, 0}, 1'b1, 1'b1, "R4 concat one digit");
    send_eq(32'd1510, 2, '{15, 10, 0, 0}, 1'b1, 1'b1, "R4 concat two digits");
    send_eq(32'd7290, 4, '{6, 8, 6, 15}, 1'b1, 1'b1, "R4 mixed chain");
    check(sum_out == 65575 + 156 + 1510 + 7290, "R4 sum value", 64'(sum_out), 65575 + 156 + 1510 + 7290);

    // R9: idle after done keeps state
    repeat (8) @(negedge clk);
    check(done == 1, "R9 done held", 64'(done), 1);
    check(sum_out == exp_sum, "R9 sum stable", 64'(sum_out), 64'(exp_sum));

    // sweep: batches of eight equations over both modes
    for (int b = 0; b < 30; b++) begin
      for (int e = 0; e < 8; e++) begin
        logic [31:0] o [4];
        logic [127:0] v;
        logic [31:0] t;
        int c;
        c = 1 + int'(rnd() % 4);
        for (int k = 0; k < 4; k++)
          o[k] = (rnd() % 4 == 0) ? 1 + rnd() % 200 : 1 + rnd() % 12;
        v = 128'(o[0]);
        for (int k = 1; k < c; k++) v = apply_op(int'(rnd() % (b[0] ? 3 : 2)), v, o[k]);
        t = (v >= 128'h1_0000_0000) ? 1 + rnd() % 1000 : v[31:0];
        if (rnd() % 3 == 0) t = t + 1;
        send_eq(t, c, o, b[0], e == 7, b[0] ? "R4 sweep sum" : "R3 sweep sum");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule